// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the packed partial syndromes left by a BCH remainder stage into the full set of 2t syndromes S_1 to S_2t over GF(2^13). A start pulse latches the correction capability t. The unit then reads the packed partial-syndrome words through a small word-addressed port and builds each odd syndrome bit-serially, one candidate power of alpha per cycle. After the odd syndromes it forms every even syndrome by squaring a lower syndrome. The results sit in a register array that the error-locator stage reads through an index port. A one-cycle done pulse tells that stage when to begin.

The unit has no streaming interface. The partial-syndrome port is a plain address and data pair: the source must return the word at `rem_addr` in the same cycle, with no handshake and no back-pressure. The syndrome read port is combinational. A start is honoured only when the unit is idle. A start that carries an illegal t is refused with a one-cycle reject pulse.

Top module: `bch_syn_expand`

## Requirements
- R1: A start in idle is accepted only when `cap_t` is 2, 4, 8, 12 or 24. Any other value raises `cap_bad` for exactly one cycle, starting one cycle after the start. A refused start produces no done pulse and leaves every syndrome slot unchanged. An accepted start never raises `cap_bad`.
- R2: Partial entry k (0 ≤ k < t) is read from word k/2 of the partial-syndrome port. Bits 15:0 of that word are used when k is even, and bits 31:16 when k is odd.
- R3: Slot 2k+1 receives S_(2k+1): the XOR of alpha^((2k+1)·j mod 8191) over every bit j in 0..12 that is set in partial entry k. Bits 15:13 of each 16-bit entry have no effect. The field is GF(2^13) with primitive polynomial x^13 + x^4 + x^3 + x + 1, and alpha is the element 2.
- R4: Slot 2j (1 ≤ j ≤ t) receives 0 when S_j is 0. Otherwise it receives alpha^((2·log S_j) mod 8191).
- R5: All 48 slots are cleared when a computation is accepted. After the run, slots above 2t read 0.
- R6: `done` is high for exactly one cycle per accepted start, and only once slots 1 to 2t hold their final values. A start that arrives while a computation is running is ignored.
- R7: After reset, `done` and `cap_bad` are low and every slot reads 0.
- R8: `syn_val` shows slot `syn_idx` combinationally. An index of 0, or one above 48, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (acted on in idle only) |
| cap_t | input | 5 | Correction capability t |
| rem_addr | output | 4 | Word address into the partial-syndrome store |
| rem_data | input | 32 | Word at `rem_addr`, valid in the same cycle |
| syn_idx | input | 6 | Syndrome slot to read |
| syn_val | output | 13 | Content of slot `syn_idx` |
| done | output | 1 | One-cycle pulse when the syndromes are final |
| cap_bad | output | 1 | One-cycle pulse when a start is refused |

## Verification
The assertions assume that the partial-syndrome source answers combinationally and holds the stored words steady for the whole computation. They also assume that `start` is a clean synchronous level. The bench satisfies this by loading its word array only while the unit is idle, and by driving `start`, `cap_t` and `syn_idx` just after the falling edge. The bench also drives `start` while a run is in progress with a different capability, so the guard on the latched t and the single-done rule are both exercised.

// File: rtl/bch_syn_pkg.sv
`timescale 1ns/1ps
package bch_syn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BITS,
    ST_EVEN
  } syn_state_e;
endpackage

// File: rtl/bch_gf_mul.sv
`timescale 1ns/1ps
// Combinational GF(2^M) multiplier, MSB-first Horner chain.
module bch_gf_mul #(
  parameter int M = 13,
  parameter logic [M-1:0] POLY = 13'h001B
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] y
);
  logic [M-1:0] acc [0:M];

  assign acc[0] = '0;

  for (genvar i = 0; i < M; i++) begin : g_stage
    logic [M-1:0] dbl;
    assign dbl        = {acc[i][M-2:0], 1'b0} ^ (acc[i][M-1] ? POLY : '0);
    assign acc[i + 1] = dbl ^ (b[M-1-i] ? a : '0);
  end

  assign y = acc[M];
endmodule

// File: rtl/bch_cap_check.sv
`timescale 1ns/1ps
// Legal correction capability decode.
module bch_cap_check #(
  parameter int TW    = 5,
  parameter int MAX_T = 24
) (
  input  logic [TW-1:0] t,
  output logic          ok
);
  logic in_set;

  always_comb begin
    case (int'(t))
      2, 4, 8, 12, 24: in_set = 1'b1;
      default:         in_set = 1'b0;
    endcase
  end

  assign ok = in_set && (int'(t) <= MAX_T);
endmodule

// File: rtl/bch_syn_regs.sv
`timescale 1ns/1ps
// Syndrome slot array: one write port, two combinational read ports.
module bch_syn_regs #(
  parameter int M     = 13,
  parameter int NSLOT = 48,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [M-1:0]  wdat,
  input  logic [IW-1:0] ridx_a,
  output logic [M-1:0]  rdat_a,
  input  logic [IW-1:0] ridx_b,
  output logic [M-1:0]  rdat_b
);
  logic [NSLOT*M-1:0] flat;

  for (genvar s = 1; s <= NSLOT; s++) begin : g_slot
    logic [M-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (clr)                        q <= '0;
      else if (we && (widx == IW'(s)))     q <= wdat;
    end
    assign flat[(s-1)*M +: M] = q;
  end

  always_comb begin
    rdat_a = '0;
    rdat_b = '0;
    for (int s = 1; s <= NSLOT; s++) begin
      if (ridx_a == IW'(s)) rdat_a = flat[(s-1)*M +: M];
      if (ridx_b == IW'(s)) rdat_b = flat[(s-1)*M +: M];
    end
  end

  // R5: every write lands inside the slot range
  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(widx) >= 1 && int'(widx) <= NSLOT));

  // R5: a clear never coincides with a write
  a_r5_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !we);
endmodule

// File: rtl/bch_syn_expand.sv
`timescale 1ns/1ps
module bch_syn_expand
  import bch_syn_pkg::*;
#(
  parameter int M = 13,
  parameter logic [M-1:0] POLY = 13'h001B,
  parameter int MAX_T = 24,
  localparam int NSLOT = 2 * MAX_T,
  localparam int IW = $clog2(NSLOT + 1),
  localparam int TW = $clog2(MAX_T + 1),
  localparam int AW = $clog2(MAX_T / 2 + 1),
  localparam int JW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] cap_t,
  output logic [AW-1:0] rem_addr,
  input  logic [31:0]   rem_data,
  input  logic [IW-1:0] syn_idx,
  output logic [M-1:0]  syn_val,
  output logic          done,
  output logic          cap_bad
);
  localparam logic [M-1:0] ALPHA1 = M'(2);
  localparam logic [M-1:0] ALPHA2 = M'(4);

  syn_state_e    st;
  logic [TW-1:0] t_q;
  logic [TW-1:0] k;
  logic [JW-1:0] j;
  logic [IW-1:0] m;
  logic [M-1:0]  preg, p, beta, acc;

  logic          cap_ok;
  logic [M-1:0]  mul_a, mul_b, prod, beta_nxt, rdat_b, acc_n;
  logic [15:0]   half;
  logic          clr, we;
  logic [IW-1:0] widx, ridx_b;
  logic [M-1:0]  wdat;
  logic          last_bit;

  bch_cap_check #(.TW(TW), .MAX_T(MAX_T)) u_cap (
    .t  (cap_t),
    .ok (cap_ok)
  );

  bch_gf_mul #(.M(M), .POLY(POLY)) u_mul_main (
    .a (mul_a),
    .b (mul_b),
    .y (prod)
  );

  bch_gf_mul #(.M(M), .POLY(POLY)) u_mul_step (
    .a (beta),
    .b (ALPHA2),
    .y (beta_nxt)
  );

  bch_syn_regs #(.M(M), .NSLOT(NSLOT), .IW(IW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .we     (we),
    .widx   (widx),
    .wdat   (wdat),
    .ridx_a (syn_idx),
    .rdat_a (syn_val),
    .ridx_b (ridx_b),
    .rdat_b (rdat_b)
  );

  // Partial entry k sits in word k/2, low half for even k.
  assign rem_addr = AW'(k >> 1);
  assign half     = k[0] ? rem_data[31:16] : rem_data[15:0];

  // Odd phase multiplies running power by alpha^i; even phase squares.
  assign mul_a    = (st == ST_EVEN) ? rdat_b : p;
  assign mul_b    = (st == ST_EVEN) ? rdat_b : beta;
  assign acc_n    = acc ^ (preg[j] ? p : '0);
  assign last_bit = (st == ST_BITS) && (j == JW'(M - 1));

  assign clr    = (st == ST_IDLE) && start && cap_ok;
  assign we     = last_bit || (st == ST_EVEN);
  assign widx   = (st == ST_EVEN) ? m : IW'({k, 1'b1});
  assign wdat   = (st == ST_EVEN) ? prod : acc_n;
  assign ridx_b = m >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      t_q     <= '0;
      k       <= '0;
      j       <= '0;
      m       <= '0;
      preg    <= '0;
      p       <= '0;
      beta    <= '0;
      acc     <= '0;
      done    <= 1'b0;
      cap_bad <= 1'b0;
    end else begin
      done    <= 1'b0;
      cap_bad <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (cap_ok) begin
              t_q  <= cap_t;
              k    <= '0;
              beta <= ALPHA1;
              st   <= ST_FETCH;
            end else begin
              cap_bad <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          preg <= half[M-1:0];
          p    <= M'(1);
          acc  <= '0;
          j    <= '0;
          st   <= ST_BITS;
        end
        ST_BITS: begin
          acc <= acc_n;
          p   <= prod;
          if (last_bit) begin
            beta <= beta_nxt;
            k    <= k + TW'(1);
            if (k + TW'(1) == t_q) begin
              m  <= IW'(2);
              st <= ST_EVEN;
            end else begin
              st <= ST_FETCH;
            end
          end else begin
            j <= j + JW'(1);
          end
        end
        ST_EVEN: begin
          if (m == IW'({t_q, 1'b0})) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            m <= m + IW'(2);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: done lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a start during a run leaves the latched capability alone
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && start) |=> $stable(t_q));

  // R1: a reject pulse follows a start and leaves the unit idle
  a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cap_bad |-> ($past(start) && st == ST_IDLE && !done));

  // R2: fetch addresses stay inside the words that t needs
  a_r2_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |-> (int'(rem_addr) < (int'(t_q) + 1) / 2));

  // R4: the even phase only reads slots below the one it writes
  a_r4_even_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EVEN) |-> (!m[0] && ridx_b < m));
endmodule

// File: tb/bch_syn_expand_bench.sv
`timescale 1ns/1ps
module bch_syn_expand_bench;
  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [4:0]  cap_t;
  logic [3:0]  rem_addr;
  logic [31:0] rem_data;
  logic [5:0]  syn_idx;
  logic [12:0] syn_val;
  logic        done, cap_bad;

  logic [31:0] mem [0:15];
  int errs = 0, checks = 0, done_cnt = 0;
  int exp_s [0:48];

  always #5 clk = ~clk;
  assign rem_data = mem[rem_addr];

  bch_syn_expand u_bch_syn_expand (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_t(cap_t),
    .rem_addr(rem_addr), .rem_data(rem_data), .syn_idx(syn_idx),
    .syn_val(syn_val), .done(done), .cap_bad(cap_bad)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  function automatic int gmul(int a, int b);
    int r = 0;
    for (int i = 0; i < 13; i++) begin
      if (b[i]) r ^= a;
      a = a << 1;
      if ((a & 32'h2000) != 0) a ^= 32'h201B;
    end
    return r;
  endfunction

  function automatic int gpow(int e);
    int r = 1, base = 2;
    e = e % 8191;
    while (e > 0) begin
      if ((e & 1) != 0) r = gmul(r, base);
      base = gmul(base, base);
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic int glog(int x);
    int v = 1;
    for (int e = 0; e < 8191; e++) begin
      if (v == x) return e;
      v = gmul(v, 2);
    end
    return 0;
  endfunction

  function automatic bit legal(int t);
    return (t == 2 || t == 4 || t == 8 || t == 12 || t == 24);
  endfunction

  task automatic build(int t);
    for (int i = 0; i <= 48; i++) exp_s[i] = 0;
    for (int k = 0; k < t; k++) begin
      int w, part, s;
      w = int'(mem[k/2]);
      part = (k % 2 == 1) ? ((w >> 16) & 16'hFFFF) : (w & 16'hFFFF);
      s = 0;
      for (int jj = 0; jj < 13; jj++)
        if (part[jj]) s ^= gpow((2*k + 1) * jj);
      exp_s[2*k + 1] = s;
    end
    for (int i = 2; i <= 2*t; i += 2) begin
      int sj;
      sj = exp_s[i/2];
      exp_s[i] = (sj == 0) ? 0 : gpow((2 * glog(sj)) % 8191);
    end
  endtask

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic read_slot(int idx, output int v);
    @(negedge clk);
    syn_idx = 6'(idx);
    #1 v = int'(syn_val);
  endtask

  task automatic check_slots(int t);
    int v;
    for (int i = 1; i <= 48; i++) begin
      read_slot(i, v);
      if (i > 2*t)       chk($sformatf("R5 slot %0d", i), v, 0);
      else if (i % 2)    chk($sformatf("R2 R3 slot %0d t=%0d", i, t), v, exp_s[i]);
      else               chk($sformatf("R4 slot %0d t=%0d", i, t), v, exp_s[i]);
    end
  endtask

  task automatic run_valid(int t);
    int n = 0, d0;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; cap_t = 5'(t);
    @(negedge clk); start = 1'b0;
    chk("R1 accepted start no reject", int'(cap_bad), 0);
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk("R6 done seen", int'(done), 1);
    @(negedge clk);
    chk("R6 done one cycle", int'(done), 0);
    chk("R6 single done", done_cnt - d0, 1);
    build(t);
    check_slots(t);
  endtask

  task automatic run_reject(int t);
    int d0, v;
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; cap_t = 5'(t);
    @(negedge clk); start = 1'b0;
    chk($sformatf("R1 reject t=%0d", t), int'(cap_bad), 1);
    @(negedge clk);
    chk("R1 reject one cycle", int'(cap_bad), 0);
    repeat (4) @(negedge clk);
    chk("R1 no done on reject", done_cnt - d0, 0);
    read_slot(1, v);
    chk("R1 slot 1 untouched", v, exp_s[1]);
    read_slot(2, v);
    chk("R1 slot 2 untouched", v, exp_s[2]);
  endtask

  task automatic fill(int pat);
    logic [31:0] lf = 32'hACE1_2357;
    for (int w = 0; w < 16; w++) begin
      case (pat)
        0: mem[w] = 32'h0;
        1: mem[w] = 32'hFFFF_FFFF;
        2: begin
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ 32'(w * 32'h9E37);
          mem[w] = lf;
        end
        default: mem[w] = (32'h1 << (w % 16)) | (32'h1 << (16 + (w * 3) % 16));
      endcase
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errs++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    summary();
  end

  initial begin
    int v, d0;
    for (int i = 0; i <= 48; i++) exp_s[i] = 0;
    fill(0);
    rst_n = 1'b0; start = 1'b0; cap_t = '0; syn_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 done low", int'(done), 0);
    chk("R7 cap_bad low", int'(cap_bad), 0);
    for (int i = 1; i <= 48; i++) begin
      read_slot(i, v);
      chk("R7 slot zero", v, 0);
    end
    read_slot(0, v);  chk("R8 index 0", v, 0);
    read_slot(49, v); chk("R8 index 49", v, 0);
    read_slot(63, v); chk("R8 index 63", v, 0);

    for (int pat = 0; pat < 4; pat++) begin
      fill(pat);
      for (int t = 0; t < 32; t++) begin
        if (legal(t)) run_valid(t);
        else run_reject(t);
      end
    end

    // R5: a smaller t after a full run leaves the upper slots clear
    fill(2);
    run_valid(24);
    run_valid(2);

    // R6: start with another t during a run is ignored
    fill(3);
    d0 = done_cnt;
    @(negedge clk); start = 1'b1; cap_t = 5'd4;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; cap_t = 5'd2;
    @(negedge clk); start = 1'b0;
    chk("R6 busy start no reject", int'(cap_bad), 0);
    repeat (400) @(negedge clk);
    chk("R6 one done for busy start", done_cnt - d0, 1);
    build(4);
    check_slots(4);
    read_slot(50, v); chk("R8 index 50", v, 0);

    summary();
  end
endmodule